// File: doc/BRIEF.md
# SMBus Slave Register Interface

This block is a slave-only target for a two-wire SMBus, running from a fast system clock. It oversamples the clock and data lines and finds the start and stop conditions. It decodes four transfer types: write-byte, read-byte, receive-byte and send-byte. It pulls the data line low through an open-drain enable, both to acknowledge and to return read data. It holds a small register set: a brightness value, a shutdown-mode value, a status value taken from an input port, and three fixed identification bytes.

A host selects a register with a command byte. A write-byte loads the data byte that follows the command. A read-byte uses a repeated start and returns the selected register. A send-byte carries only a command byte, so it only moves the register pointer. A receive-byte returns the register named by the most recent command, whichever transfer carried it. If a transfer is cut short by a start or stop before its data byte is complete, the registers keep their old values.

Top module: `smb_regif`

## Requirements
- R1: After reset, brightness reads 0x1F, shutdown mode reads 0, the data-line drive enable is low, and the command pointer selects brightness (code 0x01).
- R2: A start is the data line falling while the clock line is high, and a stop is the data line rising while the clock line is high. A stop releases the data line and returns the block to idle.
- R3: The block acknowledges only the 7-bit address 0x2C, received MSB first with the direction bit last (0 = write, 1 = read), by driving the data line low during the ninth clock. A transfer to any other address gets no acknowledge and has no effect.
- R4: Apart from the release on a start or stop, the drive enable changes only while the clock line is low.
- R5: A write-byte with command 0x01 loads data bits [4:0] into brightness. A write-byte with command 0x02 loads data bits [2:0] into shutdown mode.
- R6: A read-byte returns the selected register MSB first, with the unused upper bits read as zero.
- R7: Command 0x03 returns the 2-bit status input in bits [1:0]. Commands 0xFD, 0xFE and 0xFF return chip ID 0x09, revision 0x01 and maker ID 0x4D. Any other code reads 0x00.
- R8: A receive-byte returns the register named by the most recent command byte.
- R9: A start or stop that arrives before all eight data bits of a write are in leaves every register unchanged.
- R10: A write to command 0x03, 0xFD to 0xFF, or an unknown code is acknowledged and ignored.
- R11: A send-byte changes only the command pointer, not the register values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | When high, pull the data line low |
| status_i | input | 2 | Value returned by the status register |
| bright_o | output | 5 | Brightness register |
| shdn_o | output | 3 | Shutdown-mode register |

## Verification
Directed transfers run first. These are writes and reads to each command code, a wrong address, a send-byte followed by a receive-byte, and writes cut off by a stop after five data bits and by a start after three. Each one separates a legal register update from an update that must be dropped. A seeded random mix of all four transfer types follows, with random command codes, data bytes and status input. It is compared against a bench model of the registers and the command pointer, which shows whether the pointer tracks the last command across transfer types. A monitor on the drive enable checks that it changes only while the clock line is low.

// File: rtl/smb_regif_pkg.sv
package smb_regif_pkg;
  localparam logic [7:0] CMD_BRIGHT = 8'h01;
  localparam logic [7:0] CMD_SHDN   = 8'h02;
  localparam logic [7:0] CMD_STATUS = 8'h03;
  localparam logic [7:0] CMD_CHIPID = 8'hFD;
  localparam logic [7:0] CMD_REV    = 8'hFE;
  localparam logic [7:0] CMD_MFGID  = 8'hFF;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ACK, ST_CMD, ST_DATA, ST_TX, ST_TXACK, ST_SKIP
  } bus_st_e;
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '1;
    else        pipe_q <= {pipe_q[STAGES-1:0], line_i};
  end

  assign level_o = pipe_q[STAGES-1];
  assign rise_o  = pipe_q[STAGES-1] & ~pipe_q[STAGES];
  assign fall_o  = ~pipe_q[STAGES-1] & pipe_q[STAGES];
endmodule

// File: rtl/smb_bus_fsm.sv
module smb_bus_fsm
  import smb_regif_pkg::*;
#(
  parameter logic [6:0] ADDR7 = 7'h2C
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       sda_lvl,
  input  logic       start_evt,
  input  logic       stop_evt,
  input  logic [7:0] rd_data,
  output logic       sda_oe,
  output logic       cmd_we,
  output logic       wr_we,
  output logic [7:0] byte_o
);
  bus_st_e    state_q, state_d, nxt_q, nxt_d;
  logic [2:0] bitcnt_q, bitcnt_d;
  logic [7:0] sh_q, sh_d;
  logic       ack_on_q, ack_on_d;
  logic       oe_q, oe_d;

  assign byte_o = {sh_q[6:0], sda_lvl};

  always_comb begin
    state_d  = state_q;
    nxt_d    = nxt_q;
    bitcnt_d = bitcnt_q;
    sh_d     = sh_q;
    ack_on_d = ack_on_q;
    oe_d     = oe_q;
    cmd_we   = 1'b0;
    wr_we    = 1'b0;
    if (stop_evt) begin
      state_d  = ST_IDLE;
      oe_d     = 1'b0;
      ack_on_d = 1'b0;
    end else if (start_evt) begin
      state_d  = ST_ADDR;
      bitcnt_d = 3'd0;
      oe_d     = 1'b0;
      ack_on_d = 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR, ST_CMD, ST_DATA: begin
          if (scl_rise) begin
            sh_d     = byte_o;
            bitcnt_d = bitcnt_q + 3'd1;
            if (bitcnt_q == 3'd7) begin
              state_d = ST_ACK;
              if (state_q == ST_ADDR) begin
                if (byte_o[7:1] == ADDR7) nxt_d = byte_o[0] ? ST_TX : ST_CMD;
                else                      state_d = ST_SKIP;
              end else if (state_q == ST_CMD) begin
                cmd_we = 1'b1;
                nxt_d  = ST_DATA;
              end else begin
                wr_we  = 1'b1;
                nxt_d  = ST_SKIP;
              end
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            if (!ack_on_q) begin
              oe_d     = 1'b1;
              ack_on_d = 1'b1;
            end else begin
              ack_on_d = 1'b0;
              bitcnt_d = 3'd0;
              state_d  = nxt_q;
              if (nxt_q == ST_TX) begin
                sh_d = rd_data;
                oe_d = ~rd_data[7];
              end else begin
                oe_d = 1'b0;
              end
            end
          end
        end
        ST_TX: begin
          if (scl_rise) begin
            bitcnt_d = bitcnt_q + 3'd1;
            if (bitcnt_q == 3'd7) state_d = ST_TXACK;
          end else if (scl_fall) begin
            sh_d = {sh_q[6:0], 1'b0};
            oe_d = ~sh_q[6];
          end
        end
        ST_TXACK: begin
          if (scl_fall) begin
            oe_d    = 1'b0;
            state_d = ST_SKIP;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      nxt_q    <= ST_IDLE;
      bitcnt_q <= 3'd0;
      sh_q     <= 8'h00;
      ack_on_q <= 1'b0;
      oe_q     <= 1'b0;
    end else begin
      state_q  <= state_d;
      nxt_q    <= nxt_d;
      bitcnt_q <= bitcnt_d;
      sh_q     <= sh_d;
      ack_on_q <= ack_on_d;
      oe_q     <= oe_d;
    end
  end

  assign sda_oe = oe_q;
endmodule

// File: rtl/smb_regfile.sv
module smb_regfile
  import smb_regif_pkg::*;
#(
  parameter int         BRIGHT_W = 5,
  parameter int         SHDN_W   = 3,
  parameter int         STAT_W   = 2,
  parameter logic [7:0] CHIP_ID  = 8'h09,
  parameter logic [7:0] CHIP_REV = 8'h01,
  parameter logic [7:0] MFG_ID   = 8'h4D
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_we,
  input  logic                wr_we,
  input  logic [7:0]          byte_i,
  input  logic [STAT_W-1:0]   status_i,
  output logic [7:0]          rd_data,
  output logic [BRIGHT_W-1:0] bright_o,
  output logic [SHDN_W-1:0]   shdn_o
);
  localparam logic [BRIGHT_W-1:0] BRIGHT_RST = '1;

  logic [7:0]          ptr_q;
  logic [BRIGHT_W-1:0] bright_q;
  logic [SHDN_W-1:0]   shdn_q;
  logic                bright_en, shdn_en;

  assign bright_en = wr_we && (ptr_q == CMD_BRIGHT);
  assign shdn_en   = wr_we && (ptr_q == CMD_SHDN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q    <= CMD_BRIGHT;
      bright_q <= BRIGHT_RST;
      shdn_q   <= '0;
    end else begin
      if (cmd_we)    ptr_q    <= byte_i;
      if (bright_en) bright_q <= byte_i[BRIGHT_W-1:0];
      if (shdn_en)   shdn_q   <= byte_i[SHDN_W-1:0];
    end
  end

  always_comb begin
    unique case (ptr_q)
      CMD_BRIGHT: rd_data = {{(8-BRIGHT_W){1'b0}}, bright_q};
      CMD_SHDN:   rd_data = {{(8-SHDN_W){1'b0}}, shdn_q};
      CMD_STATUS: rd_data = {{(8-STAT_W){1'b0}}, status_i};
      CMD_CHIPID: rd_data = CHIP_ID;
      CMD_REV:    rd_data = CHIP_REV;
      CMD_MFGID:  rd_data = MFG_ID;
      default:    rd_data = 8'h00;
    endcase
  end

  assign bright_o = bright_q;
  assign shdn_o   = shdn_q;
endmodule

// File: rtl/smb_regif.sv
module smb_regif #(
  parameter logic [6:0] ADDR7       = 7'h2C,
  parameter int         SYNC_STAGES = 2,
  parameter int         BRIGHT_W    = 5,
  parameter int         SHDN_W      = 3,
  parameter int         STAT_W      = 2,
  parameter logic [7:0] CHIP_ID     = 8'h09,
  parameter logic [7:0] CHIP_REV    = 8'h01,
  parameter logic [7:0] MFG_ID      = 8'h4D
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                scl_i,
  input  logic                sda_i,
  output logic                sda_oe,
  input  logic [STAT_W-1:0]   status_i,
  output logic [BRIGHT_W-1:0] bright_o,
  output logic [SHDN_W-1:0]   shdn_o
);
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;
  logic       scl_lvl, scl_rise, scl_fall;
  logic       sda_lvl, sda_rise, sda_fall;
  logic       start_evt, stop_evt;
  logic       cmd_we, wr_we;
  logic [7:0] byte_w, rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  smb_line_sync #(.STAGES(SYNC_STAGES)) scl_sync_i (
    .clk(clk), .rst_n(rst_sync_n), .line_i(scl_i),
    .level_o(scl_lvl), .rise_o(scl_rise), .fall_o(scl_fall));

  smb_line_sync #(.STAGES(SYNC_STAGES)) sda_sync_i (
    .clk(clk), .rst_n(rst_sync_n), .line_i(sda_i),
    .level_o(sda_lvl), .rise_o(sda_rise), .fall_o(sda_fall));

  assign start_evt = sda_fall & scl_lvl;
  assign stop_evt  = sda_rise & scl_lvl;

  smb_bus_fsm #(.ADDR7(ADDR7)) fsm_i (
    .clk(clk), .rst_n(rst_sync_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_lvl(sda_lvl), .start_evt(start_evt), .stop_evt(stop_evt),
    .rd_data(rd_data), .sda_oe(sda_oe), .cmd_we(cmd_we), .wr_we(wr_we),
    .byte_o(byte_w));

  smb_regfile #(
    .BRIGHT_W(BRIGHT_W), .SHDN_W(SHDN_W), .STAT_W(STAT_W),
    .CHIP_ID(CHIP_ID), .CHIP_REV(CHIP_REV), .MFG_ID(MFG_ID)
  ) regs_i (
    .clk(clk), .rst_n(rst_sync_n), .cmd_we(cmd_we), .wr_we(wr_we),
    .byte_i(byte_w), .status_i(status_i), .rd_data(rd_data),
    .bright_o(bright_o), .shdn_o(shdn_o));
endmodule

// File: rtl/smb_regif_chk.sv
module smb_regif_chk #(
  parameter int BRIGHT_W = 5,
  parameter int SHDN_W   = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic                scl_lvl,
  input logic                start_evt,
  input logic                stop_evt,
  input logic                sda_oe,
  input logic                cmd_we,
  input logic                wr_we,
  input logic [BRIGHT_W-1:0] bright_o,
  input logic [SHDN_W-1:0]   shdn_o
);
  // R2: a stop always releases the data line
  a_r2_release_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_oe);

  // R4: drive enable rises only while the clock line is low
  a_r4_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_lvl);

  // R4: drive enable falls only with clock low, or on a start or stop
  a_r4_release_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe) |-> (!scl_lvl || $past(start_evt) || $past(stop_evt)));

  // R9: brightness holds unless a complete data byte arrived
  a_r9_bright_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_we |=> $stable(bright_o));

  // R9: shutdown mode holds unless a complete data byte arrived
  a_r9_shdn_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_we |=> $stable(shdn_o));

  // R11: a command byte never changes register values
  a_r11_cmd_no_reg_change: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_we |=> ($stable(bright_o) && $stable(shdn_o)));

  // R3: command and data strobes never coincide
  a_r3_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_we && wr_we));
endmodule

bind smb_regif smb_regif_chk #(.BRIGHT_W(BRIGHT_W), .SHDN_W(SHDN_W)) chk_i (
  .clk(clk), .rst_n(rst_sync_n), .scl_lvl(scl_lvl), .start_evt(start_evt),
  .stop_evt(stop_evt), .sda_oe(sda_oe), .cmd_we(cmd_we), .wr_we(wr_we),
  .bright_o(bright_o), .shdn_o(shdn_o));

// File: tb/smb_regif_tb.sv
module smb_regif_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 5;
  localparam int MAX_CYC    = 190000;
  localparam logic [6:0] DEV = 7'h2C;

  logic       clk, rst_n, scl_m, sda_m, sda_oe;
  logic [1:0] status_i;
  logic [4:0] bright_o;
  logic [2:0] shdn_o;
  logic       sda_bus;
  int         errors, checks, r4_viol;
  bit         done;
  logic [4:0] m_bright;
  logic [2:0] m_shdn;
  logic [7:0] m_ptr;

  assign sda_bus = sda_m & ~sda_oe;

  smb_regif dut_i (.clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_oe(sda_oe), .status_i(status_i), .bright_o(bright_o), .shdn_o(shdn_o));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // R4 monitor: drive enable must not change while the bench holds SCL high
  logic oe_prev;
  always @(negedge clk) begin
    if (rst_n && scl_m && (sda_oe != oe_prev)) r4_viol++;
    oe_prev <= sda_oe;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_reg(input logic [7:0] p, input logic [1:0] st);
    case (p)
      8'h01: return {3'b0, m_bright};
      8'h02: return {5'b0, m_shdn};
      8'h03: return {6'b0, st};
      8'hFD: return 8'h09;
      8'hFE: return 8'h01;
      8'hFF: return 8'h4D;
      default: return 8'h00;
    endcase
  endfunction

  function automatic void model_write(input logic [7:0] c, input logic [7:0] d);
    m_ptr = c;
    if (c == 8'h01) m_bright = d[4:0];
    else if (c == 8'h02) m_shdn = d[2:0];
  endfunction

  task automatic hq(); repeat (Q) @(negedge clk); endtask

  task automatic bus_start();
    sda_m = 1'b1; hq(); scl_m = 1'b1; hq(); sda_m = 1'b0; hq(); scl_m = 1'b0; hq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hq(); scl_m = 1'b1; hq(); sda_m = 1'b1; hq();
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; hq(); scl_m = 1'b1; hq(); hq(); scl_m = 1'b0; hq();
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; hq(); scl_m = 1'b1; hq(); b = sda_bus; hq(); scl_m = 1'b0; hq();
  endtask

  task automatic put_byte(input logic [7:0] v, output bit ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    ack = !b;
  endtask

  task automatic get_byte(output logic [7:0] v);
    for (int i = 7; i >= 0; i--) get_bit(v[i]);
    put_bit(1'b1);
  endtask

  task automatic wr_txn(input logic [6:0] a, input logic [7:0] c, input logic [7:0] d,
                        output bit acks);
    bit a0, a1, a2;
    bus_start(); put_byte({a, 1'b0}, a0);
    a1 = 0; a2 = 0;
    if (a0) begin put_byte(c, a1); put_byte(d, a2); end
    bus_stop();
    acks = a0 && a1 && a2;
  endtask

  task automatic rd_txn(input logic [7:0] c, output logic [7:0] v, output bit acks);
    bit a0, a1, a2;
    bus_start(); put_byte({DEV, 1'b0}, a0); put_byte(c, a1);
    bus_start(); put_byte({DEV, 1'b1}, a2); get_byte(v); bus_stop();
    acks = a0 && a1 && a2;
  endtask

  task automatic rcv_txn(output logic [7:0] v, output bit acks);
    bus_start(); put_byte({DEV, 1'b1}, acks); get_byte(v); bus_stop();
  endtask

  task automatic snd_txn(input logic [7:0] c, output bit acks);
    bit a0, a1;
    bus_start(); put_byte({DEV, 1'b0}, a0); put_byte(c, a1); bus_stop();
    acks = a0 && a1;
  endtask

  task automatic abort_txn(input logic [7:0] c, input logic [7:0] d, input int nbits,
                           input bit by_start);
    bit a0, a1;
    bus_start(); put_byte({DEV, 1'b0}, a0); put_byte(c, a1);
    for (int i = 7; i > 7 - nbits; i--) put_bit(d[i]);
    if (by_start) begin bus_start(); bus_stop(); end
    else bus_stop();
  endtask

  task automatic chk_regs(input string tag);
    chk(bright_o == m_bright, {tag, " bright"}, bright_o, m_bright);
    chk(shdn_o == m_shdn, {tag, " shdn"}, shdn_o, m_shdn);
    chk(sda_oe == 1'b0, "R2 released after stop", sda_oe, 0);
  endtask

  initial begin
    logic [7:0] v, c, d;
    bit ack;
    int seed_v, op;
    errors = 0; checks = 0; r4_viol = 0; done = 0;
    scl_m = 1'b1; sda_m = 1'b1; status_i = 2'b10; rst_n = 1'b0;
    m_bright = 5'h1F; m_shdn = 3'd0; m_ptr = 8'h01;
    seed_v = $urandom(32'd20240611);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    chk(bright_o == 5'h1F, "R1 reset bright", bright_o, 5'h1F);
    chk(shdn_o == 3'd0, "R1 reset shdn", shdn_o, 0);
    chk(sda_oe == 1'b0, "R1 reset drive", sda_oe, 0);
    rcv_txn(v, ack);
    chk(ack, "R3 read address ack", ack, 1);
    chk(v == 8'h1F, "R1 R8 receive after reset", v, 8'h1F);

    wr_txn(DEV, 8'h01, 8'h0A, ack); model_write(8'h01, 8'h0A);
    chk(ack, "R3 write acks", ack, 1);
    chk_regs("R5 write bright");
    wr_txn(DEV, 8'h02, 8'hFD, ack); model_write(8'h02, 8'hFD);
    chk_regs("R5 write shdn");
    rd_txn(8'h02, v, ack);
    chk(v == 8'h05, "R6 read shdn upper zero", v, 8'h05);

    wr_txn(7'h2D, 8'h01, 8'h03, ack);
    chk(!ack, "R3 wrong address no ack", ack, 0);
    chk_regs("R3 wrong address ignored");

    status_i = 2'b10; rd_txn(8'h03, v, ack);
    chk(v == 8'h02, "R7 status read", v, 8'h02);
    rd_txn(8'hFD, v, ack); chk(v == 8'h09, "R7 chip id", v, 8'h09);
    rd_txn(8'hFE, v, ack); chk(v == 8'h01, "R7 revision", v, 8'h01);
    rd_txn(8'hFF, v, ack); chk(v == 8'h4D, "R7 maker id", v, 8'h4D);
    rd_txn(8'h77, v, ack); chk(v == 8'h00, "R7 unknown reads zero", v, 0);

    wr_txn(DEV, 8'h03, 8'h55, ack); model_write(8'h03, 8'h55);
    chk(ack, "R10 status write acked", ack, 1);
    wr_txn(DEV, 8'hFD, 8'h00, ack); model_write(8'hFD, 8'h00);
    rd_txn(8'hFD, v, ack); chk(v == 8'h09, "R10 id write ignored", v, 8'h09);
    wr_txn(DEV, 8'h40, 8'h11, ack); model_write(8'h40, 8'h11);
    chk(ack, "R10 unknown write acked", ack, 1);
    chk_regs("R10 unknown write ignored");

    snd_txn(8'h02, ack); m_ptr = 8'h02;
    chk(ack, "R11 send-byte acked", ack, 1);
    chk_regs("R11 send-byte no change");
    rcv_txn(v, ack);
    chk(v == {5'b0, m_shdn}, "R8 R11 receive after send", v, {5'b0, m_shdn});

    abort_txn(8'h01, 8'h13, 5, 1'b0); m_ptr = 8'h01;
    chk_regs("R9 stop abort");
    abort_txn(8'h02, 8'h07, 3, 1'b1); m_ptr = 8'h02;
    chk_regs("R9 start abort");
    rcv_txn(v, ack);
    chk(v == exp_reg(m_ptr, status_i), "R8 pointer after abort", v, exp_reg(m_ptr, status_i));

    wr_txn(DEV, 8'h01, 8'hFF, ack); model_write(8'h01, 8'hFF);
    rd_txn(8'h01, v, ack);
    chk(v == 8'h1F, "R6 bright upper zero", v, 8'h1F);

    for (int it = 0; it < 40; it++) begin
      op = $urandom % 4;
      d = 8'($urandom);
      case ($urandom % 7)
        0: c = 8'h01; 1: c = 8'h02; 2: c = 8'h03; 3: c = 8'hFD;
        4: c = 8'hFE; 5: c = 8'hFF; default: c = 8'($urandom);
      endcase
      status_i = 2'($urandom);
      case (op)
        0: begin wr_txn(DEV, c, d, ack); model_write(c, d);
             chk(ack, "R5 random write ack", ack, 1); end
        1: begin rd_txn(c, v, ack); m_ptr = c;
             chk(v == exp_reg(c, status_i), "R6 random read", v, exp_reg(c, status_i)); end
        2: begin rcv_txn(v, ack);
             chk(v == exp_reg(m_ptr, status_i), "R8 random receive", v, exp_reg(m_ptr, status_i)); end
        default: begin snd_txn(c, ack); m_ptr = c; end
      endcase
      chk_regs("R5 random regs");
    end

    chk(r4_viol == 0, "R4 drive changes with SCL high", r4_viol, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (MAX_CYC) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R2 actual=0x0 expected=0x1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule